// File: doc/BRIEF.md
# Out-of-Order Micro-Operation Scheduler Window

This block is the central holding window between decode and the execution units. Decoded micro-operations arrive in program order, up to two per clock. Each carries an operation class, two source tags, a destination tag and a flag that marks the last micro-operation of its instruction. The window holds up to 24 of them. Every clock, each of six class-specific execution ports receives the oldest of its class whose sources are all complete. The window does not otherwise care about age when it issues.

Execution units report finished work by broadcasting the destination tag. Finished entries leave the window from the oldest end, up to four per clock, strictly in program order and whole instructions at a time. A flush input empties the window in one clock.

Tag value 0 means "no operand" and always reads as complete. Every micro-operation in flight needs its own nonzero destination tag.

Top module: `opsched_window`

## Requirements
- R1: The window holds at most 24 entries. `alloc_ready` is low exactly when the free slot count is below the number of asserted `alloc_valid` lanes. Lanes are filled in order: lane 1 is used only together with lane 0.
- R2: Up to two operations are accepted per clock, on an edge where `alloc_ready` is high and `flush` is low. Lane 0 is older than lane 1.
- R3: Class codes are store 0, load 1, branch 2, integer X 3, integer Y 4 and floating point 5, and the code equals the issue port index. `issue_valid[p]` rises only while `issue_ready[p]` is high, and only for an entry of class p. All six ports can issue in the same clock, one entry each. `issue_tag[p]` is the destination tag of the issued entry.
- R4: An entry can issue only when both of its source tags are complete. A blocked older entry does not stop a younger eligible entry of the same class from issuing.
- R5: Among the eligible entries of one class, the oldest is issued first.
- R6: A completion on `cmp_valid`/`cmp_tag` marks the issued entry with that destination tag as done. Entries waiting on that tag become eligible in the clock after the completion is presented, not in the same clock.
- R7: Up to four done entries retire per clock, oldest first, and retirement stops at the first entry that is not done. `retire_valid` is a thermometer code from bit 0. `retire_tag[k]` is the destination tag of the k-th oldest entry.
- R8: The micro-operations of one instruction (a run that ends at a set `alloc_last`) retire in the same clock or not at all. When an instruction does not fit in the current retire group, the group is cut back to the end of the previous instruction.
- R9: Raising `flush` for one clock empties the window. On the next clock nothing issues or retires, the full capacity is free and every tag reads as complete.
- R10: After synchronous reset the window is in the same state as after a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard all entries |
| alloc_valid | input | 2 | Per-lane allocation request |
| alloc_cls | input | 2x3 | Operation class per lane |
| alloc_src0 | input | 2x6 | First source tag per lane |
| alloc_src1 | input | 2x6 | Second source tag per lane |
| alloc_dst | input | 2x6 | Destination tag per lane |
| alloc_last | input | 2 | Last micro-operation of its instruction |
| alloc_ready | output | 1 | Room for all requested lanes |
| issue_ready | input | 6 | Execution port can take an operation |
| issue_valid | output | 6 | Operation sent to the port this clock |
| issue_tag | output | 6x6 | Destination tag of the issued operation |
| cmp_valid | input | 2 | Completion broadcast valid |
| cmp_tag | input | 2x6 | Completed destination tag |
| retire_valid | output | 4 | Thermometer of retiring entries |
| retire_tag | output | 4x6 | Destination tags of retiring entries, oldest first |

## Verification
The backpressure sweep fills the window to every count from 0 to 24 and probes single and paired requests. This separates an off-by-one in the free count from a check that ignores the request width. A per-port sweep places one operation of each class and withholds every other port's ready, so a wrong class-to-port mapping shows up. Issuing all six classes in one clock then exposes any shared arbitration.

A mixed queue puts a blocked older entry ahead of ready younger ones of the same class. It shows whether selection is oldest-eligible or merely oldest, and whether a wake-up arrives in the same clock as the completion or the next one. Retirement is swept over window depths 1 to 8 with completions given newest first, so nothing may leave before the head completes. After that the per-clock counts must follow 4, then the remainder. Two instruction-grouping cases, one with a partial group at the head and one straddling the four-wide boundary, show whether a split instruction can leak out.

// File: rtl/osw_pkg.sv
// Shared types and helpers for the scheduler window.
// Assumes ring offsets are always smaller than the ring depth.
package osw_pkg;

    localparam int CLS_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_STORE  = 3'd0,
        CLS_LOAD   = 3'd1,
        CLS_BRANCH = 3'd2,
        CLS_INTX   = 3'd3,
        CLS_INTY   = 3'd4,
        CLS_FP     = 3'd5
    } op_cls_e;

    // Advance a ring position by an offset below the ring depth.
    function automatic int ring_add(input int base, input int off, input int depth);
        int s;
        s = base + off;
        if (s >= depth) s = s - depth;
        return s;
    endfunction

endpackage

// File: rtl/osw_tag_board.sv
// Completion scoreboard: one bit per tag, set means the value is available.
// Allocation clears the destination tag, and a clear wins over a completion
// of the same tag in the same clock. Tag 0 always reads as available.
// Flush and reset mark every tag available.
module osw_tag_board #(
    parameter int TAG_W   = 6,
    parameter int ALLOC_W = 2,
    parameter int NUM_CMP = 2,
    localparam int NUM_TAGS = 1 << TAG_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush,
    input  logic [ALLOC_W-1:0]             clr_valid,
    input  logic [ALLOC_W-1:0][TAG_W-1:0]  clr_tag,
    input  logic [NUM_CMP-1:0]             set_valid,
    input  logic [NUM_CMP-1:0][TAG_W-1:0]  set_tag,
    output logic [NUM_TAGS-1:0]            tag_rdy
);

    logic [NUM_TAGS-1:0] rdy_q;

    // Record completions, then new producers, keeping tag 0 available.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rdy_q <= '1;
        end else begin
            for (int c = 0; c < NUM_CMP; c++)
                if (set_valid[c]) rdy_q[set_tag[c]] <= 1'b1;
            for (int a = 0; a < ALLOC_W; a++)
                if (clr_valid[a]) rdy_q[clr_tag[a]] <= 1'b0;
            rdy_q[0] <= 1'b1;
        end
    end

    assign tag_rdy = rdy_q;

endmodule

// File: rtl/osw_oldest_pick.sv
// Picks the oldest set candidate in a circular window, where age is
// measured from the head slot. Purely combinational.
module osw_oldest_pick #(
    parameter int DEPTH = 24,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] cand,
    input  logic [PTR_W-1:0] head,
    output logic             found,
    output logic [PTR_W-1:0] pick
);
    import osw_pkg::*;

    // Scan from youngest to oldest so the oldest match is kept last.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (cand[PTR_W'(ring_add(int'(head), i, DEPTH))]) begin
                found = 1'b1;
                pick  = PTR_W'(ring_add(int'(head), i, DEPTH));
            end
        end
    end

endmodule

// File: rtl/osw_retire_ctl.sv
// Counts how many entries retire this clock. It walks up to RET_W slots
// from the head while they are done, and cuts the count back to the last
// slot that closes an instruction. Assumes done implies occupied.
module osw_retire_ctl #(
    parameter int DEPTH = 24,
    parameter int RET_W = 4,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int RCNT_W = $clog2(RET_W + 1)
) (
    input  logic [DEPTH-1:0]  done,
    input  logic [DEPTH-1:0]  last,
    input  logic [PTR_W-1:0]  head,
    output logic [RCNT_W-1:0] ret_cnt
);
    import osw_pkg::*;

    logic run;

    // Extend the in-order done run and record each instruction end inside it.
    always_comb begin
        run     = 1'b1;
        ret_cnt = '0;
        for (int j = 0; j < RET_W; j++) begin
            run = run && done[PTR_W'(ring_add(int'(head), j, DEPTH))];
            if (run && last[PTR_W'(ring_add(int'(head), j, DEPTH))])
                ret_cnt = RCNT_W'(j + 1);
        end
    end

endmodule

// File: rtl/opsched_window.sv
// Out-of-order scheduler window. Entries are allocated in order at the
// tail, issued per class from any slot (oldest eligible first), marked done
// by tag broadcast and retired in order from the head.
// Assumes: lane 1 is valid only with lane 0; destination tags of in-flight
// entries are unique and nonzero; an instruction has at most RET_W
// micro-operations.
module opsched_window
    import osw_pkg::*;
#(
    parameter int DEPTH     = 24,
    parameter int NUM_PORTS = 6,
    parameter int ALLOC_W   = 2,
    parameter int RET_W     = 4,
    parameter int NUM_CMP   = 2,
    parameter int TAG_W     = 6,
    localparam int PTR_W    = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int NUM_TAGS = 1 << TAG_W,
    localparam int RCNT_W   = $clog2(RET_W + 1),
    localparam int ACNT_W   = $clog2(ALLOC_W + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              flush,
    input  logic [ALLOC_W-1:0]                alloc_valid,
    input  logic [ALLOC_W-1:0][CLS_W-1:0]     alloc_cls,
    input  logic [ALLOC_W-1:0][TAG_W-1:0]     alloc_src0,
    input  logic [ALLOC_W-1:0][TAG_W-1:0]     alloc_src1,
    input  logic [ALLOC_W-1:0][TAG_W-1:0]     alloc_dst,
    input  logic [ALLOC_W-1:0]                alloc_last,
    output logic                              alloc_ready,
    input  logic [NUM_PORTS-1:0]              issue_ready,
    output logic [NUM_PORTS-1:0]              issue_valid,
    output logic [NUM_PORTS-1:0][TAG_W-1:0]   issue_tag,
    input  logic [NUM_CMP-1:0]                cmp_valid,
    input  logic [NUM_CMP-1:0][TAG_W-1:0]     cmp_tag,
    output logic [RET_W-1:0]                  retire_valid,
    output logic [RET_W-1:0][TAG_W-1:0]       retire_tag
);

    logic [DEPTH-1:0]    ent_valid, ent_issued, ent_done, ent_last;
    logic [CLS_W-1:0]    ent_cls  [DEPTH];
    logic [TAG_W-1:0]    ent_src0 [DEPTH];
    logic [TAG_W-1:0]    ent_src1 [DEPTH];
    logic [TAG_W-1:0]    ent_dst  [DEPTH];
    logic [PTR_W-1:0]    head_q, tail_q;
    logic [CNT_W-1:0]    occ_q, free_cnt;
    logic [ACNT_W-1:0]   req_cnt, alloc_n;
    logic [ALLOC_W-1:0]  alloc_clr;
    logic                alloc_fire;
    logic [NUM_TAGS-1:0] tag_rdy;
    logic [RCNT_W-1:0]   ret_raw, ret_n;
    logic [PTR_W-1:0]    pick_slot [NUM_PORTS];

    // Count requested lanes and compare against free slots.
    always_comb begin
        req_cnt = '0;
        for (int a = 0; a < ALLOC_W; a++)
            req_cnt = req_cnt + ACNT_W'(alloc_valid[a]);
        free_cnt    = CNT_W'(DEPTH) - occ_q;
        alloc_ready = CNT_W'(req_cnt) <= free_cnt;
        alloc_fire  = alloc_ready && !flush;
        alloc_n     = alloc_fire ? req_cnt : '0;
        for (int a = 0; a < ALLOC_W; a++)
            alloc_clr[a] = alloc_fire && alloc_valid[a];
    end

    osw_tag_board #(
        .TAG_W  (TAG_W),
        .ALLOC_W(ALLOC_W),
        .NUM_CMP(NUM_CMP)
    ) u_board (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .clr_valid(alloc_clr),
        .clr_tag  (alloc_dst),
        .set_valid(cmp_valid),
        .set_tag  (cmp_tag),
        .tag_rdy  (tag_rdy)
    );

    // One oldest-eligible selector per execution port.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [DEPTH-1:0] cand;
        logic             found;
        logic [PTR_W-1:0] pick;

        // Mark slots of this port's class whose sources are available.
        always_comb begin
            for (int s = 0; s < DEPTH; s++)
                cand[s] = ent_valid[s] && !ent_issued[s]
                       && (ent_cls[s] == CLS_W'(p))
                       && tag_rdy[ent_src0[s]] && tag_rdy[ent_src1[s]];
        end

        osw_oldest_pick #(.DEPTH(DEPTH)) u_pick (
            .cand (cand),
            .head (head_q),
            .found(found),
            .pick (pick)
        );

        assign issue_valid[p] = found && issue_ready[p] && !flush;
        assign issue_tag[p]   = ent_dst[pick];
        assign pick_slot[p]   = pick;
    end

    osw_retire_ctl #(
        .DEPTH(DEPTH),
        .RET_W(RET_W)
    ) u_retire (
        .done   (ent_done),
        .last   (ent_last),
        .head   (head_q),
        .ret_cnt(ret_raw)
    );

    assign ret_n = flush ? '0 : ret_raw;

    // Present the retiring group as a thermometer with tags oldest first.
    always_comb begin
        for (int k = 0; k < RET_W; k++) begin
            retire_valid[k] = k < int'(ret_n);
            retire_tag[k]   = ent_dst[PTR_W'(ring_add(int'(head_q), k, DEPTH))];
        end
    end

    // Entry status flags: retire, issue, complete, allocate.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ent_valid  <= '0;
            ent_issued <= '0;
            ent_done   <= '0;
        end else begin
            for (int k = 0; k < RET_W; k++) begin
                if (k < int'(ret_n)) begin
                    ent_valid[PTR_W'(ring_add(int'(head_q), k, DEPTH))] <= 1'b0;
                    ent_done[PTR_W'(ring_add(int'(head_q), k, DEPTH))]  <= 1'b0;
                end
            end
            for (int p = 0; p < NUM_PORTS; p++)
                if (issue_valid[p]) ent_issued[pick_slot[p]] <= 1'b1;
            for (int s = 0; s < DEPTH; s++)
                for (int c = 0; c < NUM_CMP; c++)
                    if (cmp_valid[c] && ent_valid[s] && ent_issued[s]
                        && ent_dst[s] == cmp_tag[c])
                        ent_done[s] <= 1'b1;
            for (int a = 0; a < ALLOC_W; a++) begin
                if (alloc_clr[a]) begin
                    ent_valid[PTR_W'(ring_add(int'(tail_q), a, DEPTH))]  <= 1'b1;
                    ent_issued[PTR_W'(ring_add(int'(tail_q), a, DEPTH))] <= 1'b0;
                    ent_done[PTR_W'(ring_add(int'(tail_q), a, DEPTH))]   <= 1'b0;
                end
            end
        end
    end

    // Entry payload captured at allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_last <= '0;
            for (int s = 0; s < DEPTH; s++) begin
                ent_cls[s]  <= '0;
                ent_src0[s] <= '0;
                ent_src1[s] <= '0;
                ent_dst[s]  <= '0;
            end
        end else begin
            for (int a = 0; a < ALLOC_W; a++) begin
                if (alloc_clr[a]) begin
                    ent_cls[PTR_W'(ring_add(int'(tail_q), a, DEPTH))]  <= alloc_cls[a];
                    ent_src0[PTR_W'(ring_add(int'(tail_q), a, DEPTH))] <= alloc_src0[a];
                    ent_src1[PTR_W'(ring_add(int'(tail_q), a, DEPTH))] <= alloc_src1[a];
                    ent_dst[PTR_W'(ring_add(int'(tail_q), a, DEPTH))]  <= alloc_dst[a];
                    ent_last[PTR_W'(ring_add(int'(tail_q), a, DEPTH))] <= alloc_last[a];
                end
            end
        end
    end

    // Ring pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
        end else begin
            head_q <= PTR_W'(ring_add(int'(head_q), int'(ret_n), DEPTH));
            tail_q <= PTR_W'(ring_add(int'(tail_q), int'(alloc_n), DEPTH));
            occ_q  <= occ_q + CNT_W'(alloc_n) - CNT_W'(ret_n);
        end
    end

endmodule

// File: rtl/osw_checker.sv
// Temporal checks on the scheduler window, attached to it by bind.
// Observes occupancy, head position and done flags along with the ports.
module osw_checker #(
    parameter int DEPTH     = 24,
    parameter int NUM_PORTS = 6,
    parameter int ALLOC_W   = 2,
    parameter int RET_W     = 4,
    localparam int PTR_W    = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 flush,
    input logic [ALLOC_W-1:0]   alloc_valid,
    input logic                 alloc_ready,
    input logic [NUM_PORTS-1:0] issue_valid,
    input logic [NUM_PORTS-1:0] issue_ready,
    input logic [RET_W-1:0]     retire_valid,
    input logic [CNT_W-1:0]     occ,
    input logic [PTR_W-1:0]     head,
    input logic [DEPTH-1:0]     done
);

    // R1
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    // R1
    full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CNT_W'(DEPTH) && alloc_valid != '0) |-> !alloc_ready);

    // R2
    occ_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> int'(occ) <= int'($past(occ)) + ALLOC_W);

    // R3
    issue_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid & ~issue_ready) == '0);

    // R7
    retire_thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_valid & (retire_valid + 1'b1)) == '0);

    // R7
    retire_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid[0] |-> done[head]);

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occ == '0 && issue_valid == '0 && retire_valid == '0));

endmodule

bind opsched_window osw_checker #(
    .DEPTH    (DEPTH),
    .NUM_PORTS(NUM_PORTS),
    .ALLOC_W  (ALLOC_W),
    .RET_W    (RET_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .alloc_valid (alloc_valid),
    .alloc_ready (alloc_ready),
    .issue_valid (issue_valid),
    .issue_ready (issue_ready),
    .retire_valid(retire_valid),
    .occ         (occ_q),
    .head        (head_q),
    .done        (ent_done)
);

// File: tb/tb_opsched_window.sv
// Self-checking bench: sweeps fill levels, ports, issue order, wake timing,
// retire widths, instruction grouping and flush.
module tb_opsched_window;
    import osw_pkg::*;

    localparam int CLK_P     = 10;
    localparam int DEPTH     = 24;
    localparam int NUM_PORTS = 6;
    localparam int ALLOC_W   = 2;
    localparam int RET_W     = 4;
    localparam int NUM_CMP   = 2;
    localparam int TAG_W     = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic [ALLOC_W-1:0]               alloc_valid = '0;
    logic [ALLOC_W-1:0][CLS_W-1:0]    alloc_cls = '0;
    logic [ALLOC_W-1:0][TAG_W-1:0]    alloc_src0 = '0;
    logic [ALLOC_W-1:0][TAG_W-1:0]    alloc_src1 = '0;
    logic [ALLOC_W-1:0][TAG_W-1:0]    alloc_dst = '0;
    logic [ALLOC_W-1:0]               alloc_last = '0;
    logic                             alloc_ready;
    logic [NUM_PORTS-1:0]             issue_ready = '0;
    logic [NUM_PORTS-1:0]             issue_valid;
    logic [NUM_PORTS-1:0][TAG_W-1:0]  issue_tag;
    logic [NUM_CMP-1:0]               cmp_valid = '0;
    logic [NUM_CMP-1:0][TAG_W-1:0]    cmp_tag = '0;
    logic [RET_W-1:0]                 retire_valid;
    logic [RET_W-1:0][TAG_W-1:0]      retire_tag;

    int n_cmp = 0;
    int n_bad = 0;

    opsched_window dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .alloc_valid(alloc_valid), .alloc_cls(alloc_cls),
        .alloc_src0(alloc_src0), .alloc_src1(alloc_src1),
        .alloc_dst(alloc_dst), .alloc_last(alloc_last),
        .alloc_ready(alloc_ready),
        .issue_ready(issue_ready), .issue_valid(issue_valid),
        .issue_tag(issue_tag),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
        .retire_valid(retire_valid), .retire_tag(retire_tag)
    );

    always #(CLK_P / 2) clk = ~clk;

    task automatic chk(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        tick();
        flush = 1'b0;
    endtask

    task automatic alloc_one(input int cls, input int s0, input int s1,
                             input int dst, input bit last);
        alloc_valid   = 2'b01;
        alloc_cls[0]  = CLS_W'(cls);
        alloc_src0[0] = TAG_W'(s0);
        alloc_src1[0] = TAG_W'(s1);
        alloc_dst[0]  = TAG_W'(dst);
        alloc_last[0] = last;
        tick();
        alloc_valid = '0;
    endtask

    task automatic alloc_two(input int c0, input int d0, input bit l0,
                             input int c1, input int d1, input bit l1);
        alloc_valid   = 2'b11;
        alloc_cls[0]  = CLS_W'(c0);
        alloc_cls[1]  = CLS_W'(c1);
        alloc_src0    = '0;
        alloc_src1    = '0;
        alloc_dst[0]  = TAG_W'(d0);
        alloc_dst[1]  = TAG_W'(d1);
        alloc_last[0] = l0;
        alloc_last[1] = l1;
        tick();
        alloc_valid = '0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10: reset state
        alloc_valid = 2'b11;
        issue_ready = '1;
        #1;
        chk("R10 alloc_ready", alloc_ready, 1);
        chk("R10 issue_valid", issue_valid, 0);
        chk("R10 retire_valid", retire_valid, 0);
        alloc_valid = '0;
        issue_ready = '0;

        // R1: backpressure sweep over every fill level
        for (int n = 0; n <= DEPTH; n++) begin
            do_flush();
            for (int i = 0; i < n; i++) alloc_one(CLS_INTX, 0, 0, i + 1, 1'b1);
            alloc_valid = 2'b01;
            #1 chk("R1 ready one lane", alloc_ready, (n < DEPTH) ? 1 : 0);
            alloc_valid = 2'b11;
            #1 chk("R1 ready two lanes", alloc_ready, (n <= DEPTH - 2) ? 1 : 0);
            alloc_valid = '0;
        end

        // R3: each class reaches only its own port
        for (int p = 0; p < NUM_PORTS; p++) begin
            do_flush();
            alloc_one(p, 0, 0, 1, 1'b1);
            issue_ready = ~(NUM_PORTS'(1) << p);
            #1 chk("R3 other ports idle", issue_valid, 0);
            issue_ready = '1;
            #1 chk("R3 own port", issue_valid, 1 << p);
            chk("R3 tag", issue_tag[p], 1);
            issue_ready = '0;
        end

        // R3: all six ports in one clock
        do_flush();
        alloc_two(CLS_STORE, 1, 1'b1, CLS_LOAD, 2, 1'b1);
        alloc_two(CLS_BRANCH, 3, 1'b1, CLS_INTX, 4, 1'b1);
        alloc_two(CLS_INTY, 5, 1'b1, CLS_FP, 6, 1'b1);
        issue_ready = '1;
        #1 chk("R3 six at once", issue_valid, 6'h3F);
        for (int p = 0; p < NUM_PORTS; p++) chk("R3 six tags", issue_tag[p], p + 1);
        tick();
        chk("R3 one per port", issue_valid, 0);
        issue_ready = '0;

        // R4, R5, R6: oldest eligible, blocked older entry, wake timing
        do_flush();
        alloc_one(CLS_FP, 0, 0, 10, 1'b1);
        alloc_one(CLS_INTX, 10, 0, 4, 1'b1);
        alloc_one(CLS_INTX, 0, 0, 1, 1'b1);
        alloc_one(CLS_INTX, 0, 0, 2, 1'b1);
        issue_ready = NUM_PORTS'(1) << CLS_INTX;
        #1 chk("R4 younger passes blocked", issue_valid, 6'b001000);
        chk("R5 oldest eligible first", issue_tag[CLS_INTX], 1);
        tick();
        chk("R5 next oldest", issue_tag[CLS_INTX], 2);
        tick();
        chk("R4 source pending blocks", issue_valid, 0);
        issue_ready = (NUM_PORTS'(1) << CLS_FP) | (NUM_PORTS'(1) << CLS_INTX);
        #1 chk("R3 fp issues alone", issue_valid, 6'b100000);
        chk("R3 fp tag", issue_tag[CLS_FP], 10);
        tick();
        issue_ready = NUM_PORTS'(1) << CLS_INTX;
        cmp_valid = 2'b01;
        cmp_tag[0] = 6'd10;
        #1 chk("R6 no same-clock wake", issue_valid, 0);
        tick();
        cmp_valid = '0;
        chk("R6 wake next clock", issue_valid, 6'b001000);
        chk("R6 woken tag", issue_tag[CLS_INTX], 4);
        chk("R7 head retires", retire_valid, 4'b0001);
        chk("R7 head tag", retire_tag[0], 10);
        issue_ready = '0;

        // R7: retire width sweep, completions newest first
        for (int n = 1; n <= 8; n++) begin
            int rem;
            do_flush();
            for (int i = 0; i < n; i++) alloc_one(CLS_INTX, 0, 0, i + 1, 1'b1);
            issue_ready = NUM_PORTS'(1) << CLS_INTX;
            repeat (n) tick();
            issue_ready = '0;
            for (int k = n; k > 0; k -= 2) begin
                cmp_valid  = (k > 1) ? 2'b11 : 2'b01;
                cmp_tag[0] = TAG_W'(k);
                cmp_tag[1] = TAG_W'(k - 1);
                #1 chk("R7 stall behind incomplete head", retire_valid, 0);
                tick();
                cmp_valid = '0;
            end
            rem = n;
            while (rem > 0) begin
                int exp;
                exp = (rem > RET_W) ? RET_W : rem;
                chk("R7 retire count", $countones(retire_valid), exp);
                for (int j = 0; j < exp; j++)
                    chk("R7 retire order", retire_tag[j], n - rem + j + 1);
                tick();
                rem = rem - exp;
            end
            chk("R7 drained", retire_valid, 0);
        end

        // R2, R8: instruction grouping at the head
        do_flush();
        alloc_two(CLS_INTX, 1, 1'b0, CLS_INTY, 2, 1'b1);
        alloc_one(CLS_INTX, 0, 0, 3, 1'b1);
        issue_ready = (NUM_PORTS'(1) << CLS_INTX) | (NUM_PORTS'(1) << CLS_INTY);
        tick();
        tick();
        issue_ready = '0;
        cmp_valid = 2'b11;
        cmp_tag[0] = 6'd1;
        cmp_tag[1] = 6'd3;
        tick();
        cmp_valid = '0;
        chk("R8 partial instruction held", retire_valid, 0);
        cmp_valid = 2'b01;
        cmp_tag[0] = 6'd2;
        tick();
        cmp_valid = '0;
        chk("R8 whole group retires", retire_valid, 4'b0111);
        chk("R2 lane 0 older", retire_tag[0], 1);
        chk("R2 lane 1 younger", retire_tag[1], 2);
        chk("R8 following instruction", retire_tag[2], 3);

        // R8: instruction straddling the four-wide boundary
        do_flush();
        alloc_one(CLS_INTX, 0, 0, 1, 1'b1);
        alloc_one(CLS_INTX, 0, 0, 2, 1'b1);
        alloc_one(CLS_INTX, 0, 0, 3, 1'b1);
        alloc_two(CLS_INTX, 4, 1'b0, CLS_INTX, 5, 1'b1);
        issue_ready = NUM_PORTS'(1) << CLS_INTX;
        repeat (5) tick();
        issue_ready = '0;
        for (int k = 5; k > 0; k -= 2) begin
            cmp_valid  = (k > 1) ? 2'b11 : 2'b01;
            cmp_tag[0] = TAG_W'(k);
            cmp_tag[1] = TAG_W'(k - 1);
            tick();
            cmp_valid = '0;
        end
        chk("R8 group cut to boundary", retire_valid, 4'b0111);
        tick();
        chk("R8 split pair together", retire_valid, 4'b0011);
        chk("R8 pair tag first", retire_tag[0], 4);
        chk("R8 pair tag second", retire_tag[1], 5);

        // R9: flush empties window and scoreboard
        do_flush();
        alloc_one(CLS_FP, 0, 0, 7, 1'b1);
        alloc_one(CLS_INTX, 0, 0, 8, 1'b1);
        do_flush();
        alloc_valid = 2'b11;
        issue_ready = '1;
        #1 chk("R9 alloc_ready after flush", alloc_ready, 1);
        chk("R9 nothing issues", issue_valid, 0);
        chk("R9 nothing retires", retire_valid, 0);
        alloc_valid = '0;
        issue_ready = '0;
        alloc_one(CLS_INTX, 7, 0, 9, 1'b1);
        issue_ready = NUM_PORTS'(1) << CLS_INTX;
        #1 chk("R9 tags complete after flush", issue_valid, 6'b001000);
        chk("R9 issued tag", issue_tag[CLS_INTX], 9);
        issue_ready = '0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule